// File: doc/BRIEF.md
# External Interrupt Edge Detection Router

This block turns raw external request pins into sticky interrupt request flags. Four groups of asynchronous inputs enter it: one non-maskable pin, sixteen general request pins, sixteen key-scan inputs and eight wake-up inputs. Every input passes through a two-flop synchroniser. Each input is then compared with its value one cycle earlier, under a detection mode that is chosen per pin. A hit sets a request flag. The flag stays set until a one-cycle acknowledge pulse on the matching input clears it.

A single vector-extension select decides how the key inputs are used. When the select is 0, the lower eight keys are merged with general line 6 and the upper eight keys with general line 7. A key pulled low then raises the shared request under that line's own sense mode, and no key flag is set. When the select is 1, every key has its own flag, set on a falling edge, and lines 6 and 7 respond only to their own pins. The wake-up inputs use a per-pin rising-or-falling choice whatever the select is.

Prioritisation, vector generation and software register access are handled elsewhere. Configuration reaches the block as plain input ports.

Top module: `ext_irq_router`

## Requirements
- R1: `req_nmi` is set by a rising edge of `nmi_pin` when `nmi_rise_sel` is 1, and by a falling edge when it is 0. An edge of the other polarity has no effect.
- R2: General line i takes its sense mode from `irq_sense[2i+1:2i]`: 2'b00 means low level, 2'b01 falling edge, 2'b10 rising edge and 2'b11 both edges.
- R3: With `vec_ext` = 0, line 6 is the logical AND of `irq_pin[6]` and `key_pin[7:0]`, so any of them going low acts as a falling edge on line 6. No bit of `req_key` is newly set while `vec_ext` is 0.
- R4: With `vec_ext` = 0, line 7 is the logical AND of `irq_pin[7]` and `key_pin[15:8]`, and it is sensed under the mode in `irq_sense[15:14]`.
- R5: With `vec_ext` = 1, a falling edge on `key_pin[i]` sets `req_key[i]`, and a rising edge on a key has no effect. Lines 6 and 7 then see only their own pins.
- R6: A rising edge on `wake_pin[i]` sets `req_wake[i]` when `wake_rise_sel[i]` is 1, and a falling edge does so when it is 0. `vec_ext` has no effect on this.
- R7: A flag set by an edge stays set until its acknowledge bit is 1 at a clock edge. A flag in low-level mode cannot be cleared while its synchronised line is low.
- R8: When an edge is detected in the same cycle as the acknowledge for that flag, the flag stays set.
- R9: Synchronous reset clears every flag and loads all synchroniser stages with 1 (the idle-high state).
- R10: A change on a pin shows up on its flag after the third rising clock edge that follows it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_ext | input | 1 | Key routing select: 0 merges keys into lines 6/7, 1 gives each key its own flag |
| nmi_rise_sel | input | 1 | Non-maskable edge: 1 rising, 0 falling |
| irq_sense | input | 32 | Two-bit sense mode per general line |
| wake_rise_sel | input | 8 | Wake-up edge per pin: 1 rising, 0 falling |
| nmi_pin | input | 1 | Raw non-maskable request pin |
| irq_pin | input | 16 | Raw general request pins |
| key_pin | input | 16 | Raw key-scan inputs |
| wake_pin | input | 8 | Raw wake-up inputs |
| ack_nmi | input | 1 | Write-one-to-clear for req_nmi |
| ack_irq | input | 16 | Write-one-to-clear per general flag |
| ack_key | input | 16 | Write-one-to-clear per key flag |
| ack_wake | input | 8 | Write-one-to-clear per wake flag |
| req_nmi | output | 1 | Non-maskable request flag |
| req_irq | output | 16 | General request flags |
| req_key | output | 16 | Individual key request flags |
| req_wake | output | 8 | Wake-up request flags |

## Verification
The assertions check on every cycle three properties: reset empties all flags, edge-set flags for the non-maskable, key and wake groups fall only after an acknowledge, and merged routing never raises a key flag. Other properties depend on pin history and configuration, and only the bench's scenarios can show them: each sense mode against both edge polarities, exact three-edge latency, a level request resisting an acknowledge, the edge-over-acknowledge tie, and the two key routings with wake sensing unaffected. A behavioural reference model, compared on every clock through a long pseudo-random phase, covers these together.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned IRQ_N  = 16;
    localparam int unsigned KEY_N  = 16;
    localparam int unsigned WAKE_N = 8;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    // Synchronised line: value this cycle and the cycle before.
    typedef struct packed {
        logic now;
        logic was;
    } line_t;

    function automatic logic sense_hit(sense_e mode, line_t ln);
        logic hit;
        case (mode)
            SENSE_LOW:  hit = ~ln.now;
            SENSE_FALL: hit = ln.was & ~ln.now;
            SENSE_RISE: hit = ~ln.was & ln.now;
            default:    hit = ln.was ^ ln.now;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/irq_sync3.sv
// Two-flop synchroniser followed by a history stage for edge detection.
module irq_sync3 #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] was
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '1;
            cur  <= '1;
            was  <= '1;
        end else begin
            meta <= raw;
            cur  <= meta;
            was  <= cur;
        end
    end
endmodule

// File: rtl/irq_sense_bank.sv
// Applies a per-line two-bit sense mode to a bank of synchronised lines.
module irq_sense_bank
    import irq_route_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic [2*N-1:0] mode_bus,
    input  logic [N-1:0]   now,
    input  logic [N-1:0]   was,
    output logic [N-1:0]   hit
);
    for (genvar i = 0; i < N; i++) begin : g_line
        line_t ln;
        assign ln     = '{now: now[i], was: was[i]};
        assign hit[i] = sense_hit(sense_e'(mode_bus[2*i +: 2]), ln);
    end
endmodule

// File: rtl/irq_flag_reg.sv
// Sticky request flags: a hit sets, an acknowledge clears, a hit wins a tie.
module irq_flag_reg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] ack,
    output logic [N-1:0] flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= '0;
        else     flag <= hit | (flag & ~ack);
    end
endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
    import irq_route_pkg::*;
#(
    parameter int unsigned N_IRQ  = IRQ_N,
    parameter int unsigned N_KEY  = KEY_N,
    parameter int unsigned N_WAKE = WAKE_N,
    parameter int unsigned LINE_A = 6,
    parameter int unsigned LINE_B = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vec_ext,
    input  logic                nmi_rise_sel,
    input  logic [2*N_IRQ-1:0]  irq_sense,
    input  logic [N_WAKE-1:0]   wake_rise_sel,
    input  logic                nmi_pin,
    input  logic [N_IRQ-1:0]    irq_pin,
    input  logic [N_KEY-1:0]    key_pin,
    input  logic [N_WAKE-1:0]   wake_pin,
    input  logic                ack_nmi,
    input  logic [N_IRQ-1:0]    ack_irq,
    input  logic [N_KEY-1:0]    ack_key,
    input  logic [N_WAKE-1:0]   ack_wake,
    output logic                req_nmi,
    output logic [N_IRQ-1:0]    req_irq,
    output logic [N_KEY-1:0]    req_key,
    output logic [N_WAKE-1:0]   req_wake
);
    localparam int unsigned HALF   = N_KEY / 2;
    localparam int unsigned OFS_IRQ  = 1;
    localparam int unsigned OFS_KEY  = OFS_IRQ + N_IRQ;
    localparam int unsigned OFS_WAKE = OFS_KEY + N_KEY;
    localparam int unsigned RAW_N    = OFS_WAKE + N_WAKE;

    logic [RAW_N-1:0] raw_bus, cur_bus, was_bus, hit_bus, ack_bus, flag_bus;

    assign raw_bus = {wake_pin, key_pin, irq_pin, nmi_pin};

    irq_sync3 #(.W(RAW_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (raw_bus),
        .cur (cur_bus),
        .was (was_bus)
    );

    logic [N_IRQ-1:0]  cur_irq, was_irq, line_now, line_was, hit_irq;
    logic [N_KEY-1:0]  cur_key, was_key, hit_key;
    logic [N_WAKE-1:0] cur_wake, was_wake, hit_wake;
    logic              hit_nmi;

    assign cur_irq  = cur_bus[OFS_IRQ  +: N_IRQ];
    assign was_irq  = was_bus[OFS_IRQ  +: N_IRQ];
    assign cur_key  = cur_bus[OFS_KEY  +: N_KEY];
    assign was_key  = was_bus[OFS_KEY  +: N_KEY];
    assign cur_wake = cur_bus[OFS_WAKE +: N_WAKE];
    assign was_wake = was_bus[OFS_WAKE +: N_WAKE];

    // Key routing: merged lines are active-low wired ANDs of pin and keys.
    always_comb begin
        line_now = cur_irq;
        line_was = was_irq;
        if (!vec_ext) begin
            line_now[LINE_A] = cur_irq[LINE_A] & (&cur_key[HALF-1:0]);
            line_was[LINE_A] = was_irq[LINE_A] & (&was_key[HALF-1:0]);
            line_now[LINE_B] = cur_irq[LINE_B] & (&cur_key[N_KEY-1:HALF]);
            line_was[LINE_B] = was_irq[LINE_B] & (&was_key[N_KEY-1:HALF]);
        end
    end

    irq_sense_bank #(.N(N_IRQ)) u_bank (
        .mode_bus (irq_sense),
        .now      (line_now),
        .was      (line_was),
        .hit      (hit_irq)
    );

    assign hit_key  = vec_ext ? (was_key & ~cur_key) : '0;
    assign hit_wake = (wake_rise_sel & cur_wake & ~was_wake)
                    | (~wake_rise_sel & ~cur_wake & was_wake);
    assign hit_nmi  = nmi_rise_sel ? (cur_bus[0] & ~was_bus[0])
                                   : (~cur_bus[0] & was_bus[0]);

    assign hit_bus = {hit_wake, hit_key, hit_irq, hit_nmi};
    assign ack_bus = {ack_wake, ack_key, ack_irq, ack_nmi};

    irq_flag_reg #(.N(RAW_N)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit_bus),
        .ack  (ack_bus),
        .flag (flag_bus)
    );

    assign req_nmi  = flag_bus[0];
    assign req_irq  = flag_bus[OFS_IRQ  +: N_IRQ];
    assign req_key  = flag_bus[OFS_KEY  +: N_KEY];
    assign req_wake = flag_bus[OFS_WAKE +: N_WAKE];
endmodule

// File: rtl/ext_irq_router_chk.sv
module ext_irq_router_chk #(
    parameter int unsigned N_IRQ  = 16,
    parameter int unsigned N_KEY  = 16,
    parameter int unsigned N_WAKE = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              vec_ext,
    input logic              ack_nmi,
    input logic [N_KEY-1:0]  ack_key,
    input logic [N_WAKE-1:0] ack_wake,
    input logic              req_nmi,
    input logic [N_IRQ-1:0]  req_irq,
    input logic [N_KEY-1:0]  req_key,
    input logic [N_WAKE-1:0] req_wake
);
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!req_nmi && req_irq == '0 && req_key == '0 && req_wake == '0));

    assert_key_merged_R3: assert property (@(posedge clk) disable iff (rst)
        !vec_ext |=> ((req_key & ~$past(req_key)) == '0));

    assert_nmi_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (req_nmi && !ack_nmi) |=> req_nmi);

    assert_wake_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ((req_wake & ~ack_wake) != '0)
        |=> (((($past(req_wake) & ~$past(ack_wake))) & ~req_wake) == '0));

    assert_key_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ((req_key & ~ack_key) != '0)
        |=> (((($past(req_key) & ~$past(ack_key))) & ~req_key) == '0));
endmodule

bind ext_irq_router ext_irq_router_chk #(
    .N_IRQ  (N_IRQ),
    .N_KEY  (N_KEY),
    .N_WAKE (N_WAKE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .vec_ext  (vec_ext),
    .ack_nmi  (ack_nmi),
    .ack_key  (ack_key),
    .ack_wake (ack_wake),
    .req_nmi  (req_nmi),
    .req_irq  (req_irq),
    .req_key  (req_key),
    .req_wake (req_wake)
);

// File: tb/sim_ext_irq_router.sv
`timescale 1ns/1ps
module sim_ext_irq_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vec_ext = 1'b0;
    logic        nmi_rise_sel = 1'b0;
    logic [31:0] irq_sense = {16{2'b01}};
    logic [7:0]  wake_rise_sel = 8'h00;
    logic        nmi_pin = 1'b1;
    logic [15:0] irq_pin = '1;
    logic [15:0] key_pin = '1;
    logic [7:0]  wake_pin = '1;
    logic        ack_nmi = 1'b0;
    logic [15:0] ack_irq = '0;
    logic [15:0] ack_key = '0;
    logic [7:0]  ack_wake = '0;
    logic        req_nmi;
    logic [15:0] req_irq, req_key;
    logic [7:0]  req_wake;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ext_irq_router u0 (
        .clk(clk), .rst(rst), .vec_ext(vec_ext), .nmi_rise_sel(nmi_rise_sel),
        .irq_sense(irq_sense), .wake_rise_sel(wake_rise_sel),
        .nmi_pin(nmi_pin), .irq_pin(irq_pin), .key_pin(key_pin), .wake_pin(wake_pin),
        .ack_nmi(ack_nmi), .ack_irq(ack_irq), .ack_key(ack_key), .ack_wake(ack_wake),
        .req_nmi(req_nmi), .req_irq(req_irq), .req_key(req_key), .req_wake(req_wake)
    );

    // Reference model: pin history by age, flags updated from the requirements.
    logic        m_nmi;
    logic [15:0] m_irq, m_key;
    logic [7:0]  m_wake;
    logic [40:0] age1, age2, age3;

    function automatic bit mode_fires(logic [1:0] mode, bit c, bit o);
        if (mode == 2'b00) return !c;
        if (mode == 2'b01) return o && !c;
        if (mode == 2'b10) return !o && c;
        return o != c;
    endfunction

    always @(posedge clk) begin
        bit c;
        bit o;
        if (rst) begin
            m_nmi = 0; m_irq = '0; m_key = '0; m_wake = '0;
            age1 = '1; age2 = '1; age3 = '1;
        end else begin
            c = age2[0]; o = age3[0];
            if (nmi_rise_sel ? (c && !o) : (!c && o)) m_nmi = 1;
            else if (ack_nmi) m_nmi = 0;
            for (int i = 0; i < 16; i++) begin
                c = age2[1+i]; o = age3[1+i];
                if (!vec_ext && (i == 6 || i == 7)) begin
                    for (int k = 0; k < 8; k++) begin
                        c = c & age2[17 + k + (i - 6) * 8];
                        o = o & age3[17 + k + (i - 6) * 8];
                    end
                end
                if (mode_fires(irq_sense[2*i +: 2], c, o)) m_irq[i] = 1;
                else if (ack_irq[i]) m_irq[i] = 0;
            end
            for (int i = 0; i < 16; i++) begin
                if (vec_ext && age3[17+i] && !age2[17+i]) m_key[i] = 1;
                else if (ack_key[i]) m_key[i] = 0;
            end
            for (int i = 0; i < 8; i++) begin
                c = age2[33+i]; o = age3[33+i];
                if (wake_rise_sel[i] ? (c && !o) : (!c && o)) m_wake[i] = 1;
                else if (ack_wake[i]) m_wake[i] = 0;
            end
            age3 = age2; age2 = age1;
            age1 = {wake_pin, key_pin, irq_pin, nmi_pin};
        end
    end

    task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(int n = 1);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            cmp("R1 model nmi",  {15'd0, req_nmi}, {15'd0, m_nmi});
            cmp("R2 model irq",  req_irq, m_irq);
            cmp("R5 model key",  req_key, m_key);
            cmp("R6 model wake", {8'd0, req_wake}, {8'd0, m_wake});
        end
    endtask

    task automatic ack_all();
        ack_nmi = 1; ack_irq = '1; ack_key = '1; ack_wake = '1;
        tick();
        ack_nmi = 0; ack_irq = '0; ack_key = '0; ack_wake = '0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        cmp("R9 reset flags", {req_irq | req_key, req_wake, 7'd0, req_nmi}, '0);
        rst = 0;
        tick(2);

        // R1 and R10: falling NMI, latency of three edges
        nmi_pin = 0;
        tick(2);
        cmp("R10 not yet", {15'd0, req_nmi}, 16'd0);
        tick();
        cmp("R1 falling nmi", {15'd0, req_nmi}, 16'd1);
        ack_nmi = 1; tick(); ack_nmi = 0;
        cmp("R7 ack clears nmi", {15'd0, req_nmi}, 16'd0);
        nmi_pin = 1; tick(4);
        cmp("R1 rising ignored", {15'd0, req_nmi}, 16'd0);
        nmi_rise_sel = 1; nmi_pin = 0; tick(4);
        cmp("R1 falling ignored", {15'd0, req_nmi}, 16'd0);
        nmi_pin = 1; tick(3);
        cmp("R1 rising nmi", {15'd0, req_nmi}, 16'd1);
        ack_all();

        // R2: sense modes per line
        irq_sense[5:4] = 2'b10; irq_sense[9:8] = 2'b11;
        irq_sense[19:18] = 2'b01; irq_sense[7:6] = 2'b00;
        irq_pin[2] = 0; irq_pin[4] = 0; irq_pin[9] = 0;
        tick(3);
        cmp("R2 fall modes", req_irq & 16'h0214, 16'h0210);
        ack_all();
        irq_pin[2] = 1; irq_pin[4] = 1; irq_pin[9] = 1;
        tick(3);
        cmp("R2 rise modes", req_irq & 16'h0214, 16'h0014);
        ack_all();

        // R7: low-level line resists acknowledge
        irq_pin[3] = 0; tick(3);
        cmp("R2 low level", req_irq & 16'h0008, 16'h0008);
        ack_irq[3] = 1; tick(3); ack_irq[3] = 0;
        cmp("R7 level holds", req_irq & 16'h0008, 16'h0008);
        irq_pin[3] = 1; tick(3);
        ack_irq[3] = 1; tick(); ack_irq[3] = 0;
        cmp("R7 level released", req_irq & 16'h0008, 16'h0000);

        // R8: edge and acknowledge in one cycle
        irq_pin[9] = 0; tick(3);
        irq_pin[9] = 1; tick(3);
        irq_pin[9] = 0; tick(2);
        ack_irq[9] = 1; tick(); ack_irq[9] = 0;
        cmp("R8 edge beats ack", req_irq & 16'h0200, 16'h0200);
        ack_all(); tick(2);

        // R3 / R4: merged key routing
        key_pin[3] = 0; tick(3);
        cmp("R3 key to line6", req_irq & 16'h00C0, 16'h0040);
        cmp("R3 no key flag", req_key, 16'h0000);
        key_pin[3] = 1; ack_all();
        key_pin[12] = 0; tick(3);
        cmp("R4 key to line7", req_irq & 16'h00C0, 16'h0080);
        key_pin[12] = 1; tick(3); ack_all();

        // R5: individual key requests
        vec_ext = 1; tick(3);
        key_pin[5] = 0; tick(3);
        cmp("R5 key falling", req_key, 16'h0020);
        cmp("R5 line6 quiet", req_irq & 16'h00C0, 16'h0000);
        key_pin[5] = 1; tick(3);
        cmp("R5 key rising ignored", req_key, 16'h0020);
        ack_all();

        // R6: wake edges independent of select
        wake_rise_sel = 8'h0F; wake_pin = 8'h00; tick(3);
        cmp("R6 wake falling", {8'd0, req_wake}, 16'h00F0);
        vec_ext = 0; wake_pin = 8'hFF; tick(3);
        cmp("R6 wake rising", {8'd0, req_wake}, 16'h00FF);
        ack_all(); tick(2);

        // Pseudo-random phase against the model
        for (int blk = 0; blk < 30; blk++) begin
            irq_sense = $urandom; wake_rise_sel = 8'($urandom);
            nmi_rise_sel = 1'($urandom); vec_ext = 1'($urandom);
            for (int cy = 0; cy < 100; cy++) begin
                nmi_pin  = 1'($urandom % 8 != 0);
                irq_pin  = 16'($urandom) | 16'($urandom);
                key_pin  = 16'($urandom) | 16'($urandom) | 16'($urandom);
                wake_pin = 8'($urandom);
                ack_nmi  = 1'($urandom); ack_irq = 16'($urandom);
                ack_key  = 16'($urandom); ack_wake = 8'($urandom);
                tick();
            end
        end
        ack_nmi = 0; ack_irq = '0; ack_key = '0; ack_wake = '0;
        tick(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule